// File: doc/BRIEF.md
# Fence and Privilege Guard

This block sits beside the control sequencer of a small accumulator machine and enforces the separation between the supervisor and user programs. It has three jobs. It keeps a boundary address, and it suppresses any data access that a user program makes below that address. It refuses opcodes above a configurable threshold while the machine runs in user mode. It also runs a down-counting watchdog timer, so that a user program cannot hold the processor forever.

The sequencer raises a strobe when the memory address register has been loaded for a data access, and it raises a second strobe when an opcode has been decoded. A suppressed access is signalled on the inhibit output in the same cycle, so the memory read or write does not take place. Each of the three event flags latches and stays set until the handler clears it. The boundary, the timer and the mode bit can only be written while the machine is in supervisor mode. The interrupt cycle returns the machine to supervisor mode through a dedicated entry input.

Top module: `guard_unit`

## Requirements
- R1: After reset the mode is supervisor (mode_o = 1), the boundary equals the RST_FENCE parameter, the timer count is 0, all three flags are 0 and inhibit_o is 0.
- R2: When mode_o is 0 and mem_chk_i is high, inhibit_o is 1 in that same cycle if mar_i is strictly less than the boundary. It is 0 when mar_i is equal to or above the boundary.
- R3: A cycle with inhibit_o high sets mem_viol_o at the next clock edge.
- R4: When mode_o is 0 and op_chk_i is high, an op_i value greater than LAST_OPEN_OP (59 by default) sets priv_viol_o at the next edge. An op_i value of LAST_OPEN_OP or below does not set it.
- R5: When mode_o is 1, neither check has any effect: inhibit_o stays 0, and no flag is set by mem_chk_i or op_chk_i.
- R6: fence_we_i, tmr_we_i and mode_we_i take effect at the next edge only when mode_o is 1. When mode_o is 0, the target register keeps its value and priv_viol_o is set at the next edge.
- R7: enter_sup_i sets mode_o to 1 at the next edge, and it takes priority over a mode write in the same cycle.
- R8: A permitted timer write loads tmr_wdata_i. Otherwise a nonzero count decreases by 1 each cycle, and a count of 0 stays at 0. tmr_flag_o is set at the edge where the count steps from 1 to 0. A loaded value of 0 does not set it, and a load takes priority over the step.
- R9: Each flag stays set until clr_flags_i is high. If a flag is cleared and triggered in the same cycle, the flag ends up set.
- R10: A permitted mode write loads mode_wdata_i, where 1 is supervisor and 0 is user.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_we_i | input | 1 | Mode bit write request |
| mode_wdata_i | input | 1 | New mode (1 supervisor, 0 user) |
| enter_sup_i | input | 1 | Interrupt-cycle entry into supervisor mode |
| fence_we_i | input | 1 | Boundary write request |
| fence_wdata_i | input | ADDR_W | New boundary address |
| tmr_we_i | input | 1 | Timer load request |
| tmr_wdata_i | input | TMR_W | Timer load value |
| mem_chk_i | input | 1 | Data access address is valid on mar_i |
| mar_i | input | ADDR_W | Data access address |
| op_chk_i | input | 1 | Decoded opcode is valid on op_i |
| op_i | input | OP_W | Current opcode |
| clr_flags_i | input | 1 | Clears all three flags |
| inhibit_o | output | 1 | Suppress the current memory access |
| mem_viol_o | output | 1 | Sticky memory-violation flag |
| priv_viol_o | output | 1 | Sticky privileged-instruction flag |
| tmr_flag_o | output | 1 | Sticky timer-expiry flag |
| mode_o | output | 1 | Current mode |
| fence_o | output | ADDR_W | Current boundary |
| tmr_cnt_o | output | TMR_W | Current timer count |

## Verification
The bench builds the block with an 8-bit address and a boundary that resets to 100. Random addresses therefore land on both sides of the boundary often, and they hit the exact boundary value. The timer is 4 bits wide, so random loads run down to expiry within a few cycles, and the step from 1 to 0, the hold at 0 and a reload at 1 all occur many times. The opcode is 7 bits wide with the threshold left at 59, so opcodes 59 and 60 and the whole privileged range are reachable.

// File: rtl/guard_pkg.sv
package guard_pkg;

    typedef struct packed {
        logic mem_viol;
        logic priv_viol;
        logic tmr_hit;
    } flags_t;

    localparam flags_t FLAGS_NONE = '{mem_viol: 1'b0, priv_viol: 1'b0, tmr_hit: 1'b0};

endpackage

// File: rtl/guard_fence.sv
module guard_fence #(
    parameter int ADDR_W    = 16,
    parameter int RST_FENCE = 4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  logic [ADDR_W-1:0] wr_val,
    input  logic              chk,
    input  logic              user,
    input  logic [ADDR_W-1:0] addr,
    output logic              block_o,
    output logic [ADDR_W-1:0] fence_o
);
    localparam logic [ADDR_W-1:0] FENCE_INIT = ADDR_W'(RST_FENCE);

    typedef struct packed {
        logic [ADDR_W-1:0] fence;
    } fence_st_t;

    fence_st_t st_d, st_q;
    logic      below;

    always_comb begin
        st_d = st_q;
        if (wr_ok) begin
            st_d.fence = wr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.fence <= FENCE_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign below   = addr < st_q.fence;
    assign block_o = chk & user & below;
    assign fence_o = st_q.fence;

    AST_FENCE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> fence_o == $past(wr_val)); // R6

    AST_FENCE_AT_OR_ABOVE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (addr >= fence_o) |-> !block_o); // R2

endmodule

// File: rtl/guard_priv.sv
module guard_priv #(
    parameter int OP_W         = 8,
    parameter int LAST_OPEN_OP = 59
) (
    input  logic            op_chk,
    input  logic [OP_W-1:0] op,
    input  logic            user,
    input  logic            wr_try,
    output logic            viol_o
);
    localparam logic [OP_W-1:0] OPEN_MAX = OP_W'(LAST_OPEN_OP);

    logic priv_op;
    logic bad_op;

    always_comb begin
        priv_op = op > OPEN_MAX;
        bad_op  = op_chk & priv_op;
        viol_o  = user & (bad_op | wr_try);
    end

endmodule

// File: rtl/guard_timer.sv
module guard_timer #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [TMR_W-1:0] ld_val,
    output logic [TMR_W-1:0] cnt_o,
    output logic             expire_o
);
    localparam logic [TMR_W-1:0] ONE  = TMR_W'(1);
    localparam logic [TMR_W-1:0] ZERO = '0;

    typedef struct packed {
        logic [TMR_W-1:0] cnt;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        expire_o = 1'b0;
        if (ld) begin
            st_d.cnt = ld_val;
        end else if (st_q.cnt != ZERO) begin
            st_d.cnt = st_q.cnt - ONE;
            expire_o = (st_q.cnt == ONE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= ZERO;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

    AST_TMR_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == ZERO && !ld) |=> cnt_o == ZERO); // R8

    AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o != ZERO && !ld) |=> cnt_o == $past(cnt_o) - ONE); // R8

    AST_TMR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> cnt_o == $past(ld_val)); // R8

endmodule

// File: rtl/guard_unit.sv
module guard_unit
    import guard_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int RST_FENCE    = 4000,
    parameter int OP_W         = 8,
    parameter int LAST_OPEN_OP = 59,
    parameter int TMR_W        = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we_i,
    input  logic              mode_wdata_i,
    input  logic              enter_sup_i,
    input  logic              fence_we_i,
    input  logic [ADDR_W-1:0] fence_wdata_i,
    input  logic              tmr_we_i,
    input  logic [TMR_W-1:0]  tmr_wdata_i,
    input  logic              mem_chk_i,
    input  logic [ADDR_W-1:0] mar_i,
    input  logic              op_chk_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic              clr_flags_i,
    output logic              inhibit_o,
    output logic              mem_viol_o,
    output logic              priv_viol_o,
    output logic              tmr_flag_o,
    output logic              mode_o,
    output logic [ADDR_W-1:0] fence_o,
    output logic [TMR_W-1:0]  tmr_cnt_o
);
    localparam logic [OP_W-1:0]  OPEN_MAX = OP_W'(LAST_OPEN_OP);
    localparam logic [TMR_W-1:0] TMR_ONE  = TMR_W'(1);

    typedef struct packed {
        logic   mode;
        flags_t flg;
    } unit_st_t;

    unit_st_t st_d, st_q;

    logic sup;
    logic user;
    logic wr_try;
    logic fence_block;
    logic priv_hit;
    logic tmr_exp;

    assign sup    = st_q.mode;
    assign user   = ~st_q.mode;
    assign wr_try = fence_we_i | tmr_we_i | mode_we_i;

    guard_fence #(
        .ADDR_W    (ADDR_W),
        .RST_FENCE (RST_FENCE)
    ) i_fence (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ok   (fence_we_i & sup),
        .wr_val  (fence_wdata_i),
        .chk     (mem_chk_i),
        .user    (user),
        .addr    (mar_i),
        .block_o (fence_block),
        .fence_o (fence_o)
    );

    guard_priv #(
        .OP_W         (OP_W),
        .LAST_OPEN_OP (LAST_OPEN_OP)
    ) i_priv (
        .op_chk (op_chk_i),
        .op     (op_i),
        .user   (user),
        .wr_try (wr_try),
        .viol_o (priv_hit)
    );

    guard_timer #(
        .TMR_W (TMR_W)
    ) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (tmr_we_i & sup),
        .ld_val   (tmr_wdata_i),
        .cnt_o    (tmr_cnt_o),
        .expire_o (tmr_exp)
    );

    always_comb begin
        st_d = st_q;
        if (clr_flags_i) begin
            st_d.flg = FLAGS_NONE;
        end
        if (fence_block) begin
            st_d.flg.mem_viol = 1'b1;
        end
        if (priv_hit) begin
            st_d.flg.priv_viol = 1'b1;
        end
        if (tmr_exp) begin
            st_d.flg.tmr_hit = 1'b1;
        end
        if (mode_we_i && sup) begin
            st_d.mode = mode_wdata_i;
        end
        if (enter_sup_i) begin
            st_d.mode = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode <= 1'b1;
            st_q.flg  <= FLAGS_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign inhibit_o   = fence_block;
    assign mem_viol_o  = st_q.flg.mem_viol;
    assign priv_viol_o = st_q.flg.priv_viol;
    assign tmr_flag_o  = st_q.flg.tmr_hit;
    assign mode_o      = st_q.mode;

    AST_BLOCK_SETS_MV: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit_o |=> mem_viol_o); // R3

    AST_SUP_NO_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o |-> !inhibit_o); // R5

    AST_PRIV_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_chk_i && !mode_o && op_i > OPEN_MAX) |=> priv_viol_o); // R4

    AST_USER_WRITE_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_o && (fence_we_i || tmr_we_i || mode_we_i)) |=> priv_viol_o); // R6

    AST_USER_FENCE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_o && fence_we_i) |=> $stable(fence_o)); // R6

    AST_STICKY_MV: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_viol_o && !clr_flags_i) |=> mem_viol_o); // R9

    AST_STICKY_PV: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_viol_o && !clr_flags_i) |=> priv_viol_o); // R9

    AST_ENTER_SUP: assert property (@(posedge clk) disable iff (!rst_n)
        enter_sup_i |=> mode_o); // R7

    AST_TMR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_cnt_o == TMR_ONE && !(tmr_we_i && mode_o)) |=> tmr_flag_o); // R8

endmodule

// File: tb/test_guard_unit.sv
module test_guard_unit;

    localparam int AW = 8;
    localparam int FR = 100;
    localparam int OW = 7;
    localparam int LO = 59;
    localparam int TW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_we = 1'b0, mode_wd = 1'b0, enter = 1'b0;
    logic          fence_we = 1'b0;
    logic [AW-1:0] fence_wd = '0;
    logic          tmr_we = 1'b0;
    logic [TW-1:0] tmr_wd = '0;
    logic          mem_chk = 1'b0;
    logic [AW-1:0] mar = '0;
    logic          op_chk = 1'b0;
    logic [OW-1:0] op = '0;
    logic          clr = 1'b0;
    logic          inhibit, mv, pv, tf, mode;
    logic [AW-1:0] fence;
    logic [TW-1:0] tcnt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic last_inh;

    logic          m_mode, m_mv, m_pv, m_tf;
    logic [AW-1:0] m_fence;
    logic [TW-1:0] m_cnt;

    always #10 clk = ~clk;

    guard_unit #(
        .ADDR_W(AW), .RST_FENCE(FR), .OP_W(OW), .LAST_OPEN_OP(LO), .TMR_W(TW)
    ) i_guard_unit (
        .clk(clk), .rst_n(rst_n),
        .mode_we_i(mode_we), .mode_wdata_i(mode_wd), .enter_sup_i(enter),
        .fence_we_i(fence_we), .fence_wdata_i(fence_wd),
        .tmr_we_i(tmr_we), .tmr_wdata_i(tmr_wd),
        .mem_chk_i(mem_chk), .mar_i(mar), .op_chk_i(op_chk), .op_i(op),
        .clr_flags_i(clr),
        .inhibit_o(inhibit), .mem_viol_o(mv), .priv_viol_o(pv), .tmr_flag_o(tf),
        .mode_o(mode), .fence_o(fence), .tmr_cnt_o(tcnt)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic exp_inhibit();
        return mem_chk && !m_mode && (mar < m_fence);
    endfunction

    function automatic logic exp_priv_event();
        return !m_mode && ((op_chk && op > OW'(LO)) || fence_we || tmr_we || mode_we);
    endfunction

    task automatic compare_all();
        chk("R10 mode", int'(mode), int'(m_mode));
        chk("R6 fence", int'(fence), int'(m_fence));
        chk("R8 timer count", int'(tcnt), int'(m_cnt));
        chk("R3 mem flag", int'(mv), int'(m_mv));
        chk("R4 priv flag", int'(pv), int'(m_pv));
        chk("R8 timer flag", int'(tf), int'(m_tf));
    endtask

    task automatic drive(input logic a_mwe, input logic a_mwd, input logic a_ent,
                         input logic a_fwe, input int a_fwd, input logic a_twe,
                         input int a_twd, input logic a_mchk, input int a_mar,
                         input logic a_ochk, input int a_op, input logic a_clr);
        logic inh, pev, tload, expire;
        @(negedge clk);
        mode_we = a_mwe; mode_wd = a_mwd; enter = a_ent;
        fence_we = a_fwe; fence_wd = AW'(a_fwd);
        tmr_we = a_twe; tmr_wd = TW'(a_twd);
        mem_chk = a_mchk; mar = AW'(a_mar);
        op_chk = a_ochk; op = OW'(a_op); clr = a_clr;
        #1;
        inh = exp_inhibit();
        last_inh = inhibit;
        chk("R2 inhibit", int'(inhibit), int'(inh));
        pev    = exp_priv_event();
        tload  = tmr_we && m_mode;
        expire = !tload && (m_cnt == TW'(1));
        @(posedge clk);
        m_mv = (m_mv && !clr) || inh;
        m_pv = (m_pv && !clr) || pev;
        m_tf = (m_tf && !clr) || expire;
        if (fence_we && m_mode) m_fence = fence_wd;
        if (tload) m_cnt = tmr_wd;
        else if (m_cnt != '0) m_cnt = m_cnt - TW'(1);
        if (mode_we && m_mode) m_mode = mode_wd;
        if (enter) m_mode = 1'b1;
        #1;
        compare_all();
    endtask

    task automatic idle();
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        m_mode = 1'b1; m_mv = 1'b0; m_pv = 1'b0; m_tf = 1'b0;
        m_fence = AW'(FR); m_cnt = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1 mode", int'(mode), 1);
        chk("R1 fence", int'(fence), FR);
        chk("R1 count", int'(tcnt), 0);
        chk("R1 flags", int'({mv, pv, tf}), 0);
        chk("R1 inhibit", int'(inhibit), 0);

        // R5: supervisor checks have no effect
        drive(0, 0, 0, 0, 0, 0, 0, 1, 5, 1, 70, 0);
        chk("R5 inhibit", int'(last_inh), 0);
        chk("R5 flags", int'({mv, pv}), 0);

        drive(0, 0, 0, 1, 50, 0, 0, 0, 0, 0, 0, 0);
        chk("R6 fence write", int'(fence), 50);
        drive(0, 0, 0, 0, 0, 1, 3, 0, 0, 0, 0, 0);
        chk("R8 load", int'(tcnt), 3);
        drive(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        chk("R10 user mode", int'(mode), 0);

        drive(0, 0, 0, 0, 0, 0, 0, 1, 49, 0, 0, 0);
        chk("R2 below", int'(last_inh), 1);
        chk("R3 flag", int'(mv), 1);
        drive(0, 0, 0, 0, 0, 0, 0, 1, 50, 0, 0, 0);
        chk("R2 at fence", int'(last_inh), 0);
        chk("R8 expire", int'(tf), 1);
        idle();
        chk("R8 hold zero", int'(tcnt), 0);

        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 59, 0);
        chk("R4 op 59", int'(pv), 0);
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 60, 0);
        chk("R4 op 60", int'(pv), 1);
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        chk("R9 clear", int'({mv, pv, tf}), 0);

        drive(0, 0, 0, 1, 10, 0, 0, 0, 0, 0, 0, 0);
        chk("R6 user fence held", int'(fence), 50);
        chk("R6 user write flag", int'(pv), 1);
        drive(0, 0, 0, 0, 0, 0, 0, 1, 3, 0, 0, 1);
        chk("R9 set wins", int'(mv), 1);
        chk("R9 cleared", int'(pv), 0);

        drive(1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        chk("R7 enter wins", int'(mode), 1);
        drive(0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
        chk("R8 zero load", int'(tf), 0);

        for (int i = 0; i < 4000; i++) begin
            drive(($urandom % 8) == 0, $urandom % 2, ($urandom % 16) == 0,
                  ($urandom % 10) == 0, int'($urandom % 256),
                  ($urandom % 6) == 0, int'($urandom % 16),
                  $urandom % 2, int'($urandom % 256),
                  $urandom % 2, int'($urandom % 128),
                  ($urandom % 8) == 0);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule